// File: doc/BRIEF.md
# Four-Segment Hybrid Final Adder

This block is the last stage of a sum-of-products datapath. After the partial products have been compressed down to two operands, this adder produces their sum. The bits of those two operands do not arrive together. The low bits settle first, the middle bits last, and the top bits somewhat before the middle. The adder therefore splits the word into four contiguous segments, and each segment uses the carry structure that suits its arrival profile.

From the LSB upward the segments are as follows:

1. A full-adder ripple chain.
2. A Kogge-Stone parallel-prefix segment.
3. A carry-select segment.
4. A second carry-select segment.

Each carry-select segment holds two Brent-Kung prefix adders. One assumes an incoming carry of 0 and the other an incoming carry of 1. The real carry from below picks the result through a multiplexer.

The ripple width is set directly. The other widths default to the following rules, with R = N − W1:

- **Prefix segment:** it takes all of R when R ≤ 8. Otherwise it takes the largest power of two not above R.
- **Carry-select segments:** the third segment takes the floor of half the remainder, and the fourth segment takes the rest.

With N=32 and W1=7 the split is 7/16/4/5. A segment whose width comes out as zero is not built, and its carry passes straight through. There is no carry-in port.

Top module: `hybrid_sop_adder`

## Requirements
- R1: For every pair of operands, {cout, sum} equals the (N+1)-bit unsigned sum of a and b.
- R2: The low W1 sum bits are the low W1 bits of a[W1-1:0] + b[W1-1:0]. They depend on nothing above bit W1-1, because the chain starts with carry 0. In the default build these are bits 6..0.
- R3: Sum bit W1 (bit 7 by default) equals a[W1] XOR b[W1] XOR the carry out of the W1-bit ripple addition. The ripple carry-out therefore enters the prefix segment as its bit-0 carry.
- R4: The sum bit just above the prefix segment (bit 23 by default) equals its operand XOR plus the carry out of the (W1+W2)-bit addition of the low slices.
- R5: Each carry-select segment equals its slice of a plus its slice of b plus the true carry from the segment below. In the default build these segments are bits 26..23 and bits 31..27. Its carry-1 adder always yields exactly one more than its carry-0 adder.
- R6: The result stays exact when segments have zero width. Tested cases are a prefix-only split (32 bits, W1=0), a ripple-only split (6 bits), and a carry-select-only split (5 bits as 0/0/2/3).
- R7: With no external carry-in, zero plus zero gives sum 0 with cout 0. All ones plus one gives sum 0 with cout 1. All ones plus all ones gives all ones except bit 0, with cout 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand from the reduction stage |
| b | input | N | Second operand from the reduction stage |
| sum | output | N | Low N bits of a + b |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The embedded checks sample the block combinationally. They take for granted that both operands are fully known, and they skip evaluation while either operand holds an unknown bit. They also assume that the four widths add up to N. The bench relies on the default width rules, or on explicit splits that satisfy this, and it drives fully defined operands only once they are stable. It checks results half a clock later, so no assertion ever sees a partly updated operand pair.

// File: rtl/hybrid_sop_adder.sv
module hybrid_sop_adder #(
  parameter int N  = 32,
  parameter int W1 = 7,
  parameter int W2 = ((N - W1) <= 8) ? (N - W1) : (1 << ($clog2(N - W1 + 1) - 1)),
  parameter int W3 = (N - W1 - W2) / 2,
  parameter int W4 = N - W1 - W2 - W3
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] sum,
  output logic         cout
);

  localparam int O2 = W1;
  localparam int O3 = W1 + W2;
  localparam int O4 = W1 + W2 + W3;

  logic [N-1:0] g, p;
  logic         c_rip, c_ks;
  logic [1:0]   c_cs;

  assign g = a & b;
  assign p = a ^ b;

  if (W1 > 0) begin : g_rip
    logic [W1:0] c;
    logic [W1:0] rip_ref;
    assign c[0] = 1'b0;
    for (genvar i = 0; i < W1; i++) begin : g_fa
      assign sum[i]   = p[i] ^ c[i];
      assign c[i+1]   = g[i] | (p[i] & c[i]);
    end
    assign c_rip = c[W1];

    always_comb rip_ref = {1'b0, a[W1-1:0]} + {1'b0, b[W1-1:0]};
    always_comb if (!$isunknown({a, b})) begin
      // R2
      ripple_low_chk: assert (sum[W1-1:0] == rip_ref[W1-1:0])
        else $error("ripple segment sum mismatch");
      // R3
      ripple_carry_chk: assert (c_rip == rip_ref[W1])
        else $error("ripple carry-out mismatch");
    end
  end else begin : g_norip
    assign c_rip = 1'b0;
  end

  if (W2 > 0) begin : g_ks
    localparam int L = $clog2(W2);
    logic [W2-1:0] gk [0:L];
    logic [W2-1:0] pk [0:L];
    logic [O3:0]   ks_ref;

    for (genvar i = 0; i < W2; i++) begin : g_in
      if (i == 0) begin : g_b0
        assign gk[0][i] = g[O2] | (p[O2] & c_rip);
      end else begin : g_bn
        assign gk[0][i] = g[O2+i];
      end
      assign pk[0][i] = p[O2+i];
    end

    for (genvar l = 0; l < L; l++) begin : g_lvl
      for (genvar i = 0; i < W2; i++) begin : g_bit
        if (i >= (1 << l)) begin : g_op
          assign gk[l+1][i] = gk[l][i] | (pk[l][i] & gk[l][i-(1<<l)]);
          assign pk[l+1][i] = pk[l][i] & pk[l][i-(1<<l)];
        end else begin : g_pass
          assign gk[l+1][i] = gk[l][i];
          assign pk[l+1][i] = pk[l][i];
        end
      end
    end

    for (genvar i = 0; i < W2; i++) begin : g_sum
      if (i == 0) begin : g_s0
        assign sum[O2] = p[O2] ^ c_rip;
      end else begin : g_sn
        assign sum[O2+i] = p[O2+i] ^ gk[L][i-1];
      end
    end
    assign c_ks = gk[L][W2-1];

    always_comb ks_ref = {1'b0, a[O3-1:0]} + {1'b0, b[O3-1:0]};
    always_comb if (!$isunknown({a, b})) begin
      // R4
      ks_carry_chk: assert (c_ks == ks_ref[O3])
        else $error("prefix segment carry-out mismatch");
    end
  end else begin : g_noks
    assign c_ks = c_rip;
  end

  for (genvar s = 0; s < 2; s++) begin : g_cs
    localparam int W   = (s == 0) ? W3 : W4;
    localparam int OFF = (s == 0) ? O3 : O4;
    logic cin;
    if (s == 0) begin : g_c3
      assign cin = c_ks;
    end else begin : g_c4
      assign cin = c_cs[0];
    end

    if (W > 0) begin : g_on
      localparam int L  = $clog2(W);
      localparam int PW = 1 << L;
      localparam int NS = (L == 0) ? 0 : 2 * L - 1;
      logic [W-1:0] cand_s [0:1];
      logic [1:0]   cand_c;
      logic [W:0]   seg_ref;

      for (genvar v = 0; v < 2; v++) begin : g_bk
        logic [PW-1:0] gb [0:NS];
        logic [PW-1:0] pb [0:NS];

        for (genvar i = 0; i < PW; i++) begin : g_in
          if (i >= W) begin : g_pad
            assign gb[0][i] = 1'b0;
            assign pb[0][i] = 1'b0;
          end else if (i == 0) begin : g_b0
            assign gb[0][i] = (v == 1) ? (g[OFF] | p[OFF]) : g[OFF];
            assign pb[0][i] = p[OFF];
          end else begin : g_bn
            assign gb[0][i] = g[OFF+i];
            assign pb[0][i] = p[OFF+i];
          end
        end

        for (genvar u = 1; u <= L; u++) begin : g_up
          for (genvar i = 0; i < PW; i++) begin : g_bit
            if (((i + 1) % (1 << u)) == 0) begin : g_op
              assign gb[u][i] = gb[u-1][i] | (pb[u-1][i] & gb[u-1][i-(1<<(u-1))]);
              assign pb[u][i] = pb[u-1][i] & pb[u-1][i-(1<<(u-1))];
            end else begin : g_pass
              assign gb[u][i] = gb[u-1][i];
              assign pb[u][i] = pb[u-1][i];
            end
          end
        end

        for (genvar k = 1; k < L; k++) begin : g_dn
          for (genvar i = 0; i < PW; i++) begin : g_bit
            if ((((i + 1) % (1 << (L - k))) == (1 << (L - k - 1))) &&
                (i >= 3 * (1 << (L - k - 1)) - 1)) begin : g_op
              assign gb[L+k][i] = gb[L+k-1][i] | (pb[L+k-1][i] & gb[L+k-1][i-(1<<(L-k-1))]);
              assign pb[L+k][i] = pb[L+k-1][i] & pb[L+k-1][i-(1<<(L-k-1))];
            end else begin : g_pass
              assign gb[L+k][i] = gb[L+k-1][i];
              assign pb[L+k][i] = pb[L+k-1][i];
            end
          end
        end

        for (genvar i = 0; i < W; i++) begin : g_sum
          if (i == 0) begin : g_s0
            assign cand_s[v][0] = p[OFF] ^ (v == 1);
          end else begin : g_sn
            assign cand_s[v][i] = p[OFF+i] ^ gb[NS][i-1];
          end
        end
        assign cand_c[v] = gb[NS][W-1];
      end

      assign sum[OFF+W-1:OFF] = cin ? cand_s[1] : cand_s[0];
      assign c_cs[s]          = cin ? cand_c[1] : cand_c[0];

      always_comb seg_ref = {1'b0, a[OFF+W-1:OFF]} + {1'b0, b[OFF+W-1:OFF]} + {{W{1'b0}}, cin};
      always_comb if (!$isunknown({a, b})) begin
        // R5
        csel_pair_chk: assert ({cand_c[1], cand_s[1]} == {cand_c[0], cand_s[0]} + (W+1)'(1))
          else $error("carry-select candidates disagree");
        // R5
        csel_seg_chk: assert ({c_cs[s], sum[OFF+W-1:OFF]} == seg_ref)
          else $error("carry-select segment result mismatch");
      end
    end else begin : g_off
      assign c_cs[s] = cin;
    end
  end

  assign cout = c_cs[1];

  logic [N:0] full_ref;
  always_comb full_ref = {1'b0, a} + {1'b0, b};
  always_comb if (!$isunknown({a, b})) begin
    // R1
    full_sum_chk: assert ({cout, sum} == full_ref)
      else $error("hybrid adder total mismatch");
  end

endmodule

// File: tb/hybrid_sop_adder_bench.sv
module hybrid_sop_adder_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  logic run   = 1'b0;
  logic done  = 1'b0;

  logic [31:0] a32, b32, s32, az, bz, sz;
  logic [63:0] a64, b64, s64;
  logic [11:0] a12, b12, s12;
  logic [7:0]  a8, b8, s8;
  logic [5:0]  a6, b6, s6;
  logic [4:0]  a5, b5, s5;
  logic c32, cz, c64, c12, c8, c6, c5;

  hybrid_sop_adder u_hybrid_sop_adder (.a(a32), .b(b32), .sum(s32), .cout(c32));
  hybrid_sop_adder #(.N(32), .W1(0))  u_z   (.a(az),  .b(bz),  .sum(sz),  .cout(cz));
  hybrid_sop_adder #(.N(64), .W1(10)) u_w64 (.a(a64), .b(b64), .sum(s64), .cout(c64));
  hybrid_sop_adder #(.N(12), .W1(2))  u_w12 (.a(a12), .b(b12), .sum(s12), .cout(c12));
  hybrid_sop_adder #(.N(8), .W1(1), .W2(2), .W3(2), .W4(3)) u_w8 (.a(a8), .b(b8), .sum(s8), .cout(c8));
  hybrid_sop_adder #(.N(6), .W1(6))   u_w6  (.a(a6), .b(b6), .sum(s6), .cout(c6));
  hybrid_sop_adder #(.N(5), .W1(0), .W2(0), .W3(2), .W4(3)) u_w5 (.a(a5), .b(b5), .sum(s5), .cout(c5));

  task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] x, input logic [63:0] y, input logic [15:0] e);
    @(posedge clk);
    #1;
    a32 = x[31:0];  b32 = y[31:0];
    az  = x[63:32]; bz  = y[63:32];
    a64 = x;        b64 = y;
    a12 = x[43:32]; b12 = y[43:32];
    a8  = e[7:0];   b8  = e[15:8];
    a6  = e[5:0];   b6  = e[13:8];
    a5  = e[4:0];   b5  = e[12:8];
  endtask

  logic [7:0]  lo7;
  logic [23:0] lo23;
  logic [27:0] lo27;
  logic [42:0] lo42;
  logic [5:0]  seg4;

  always @(negedge clk) if (run) begin
    chk("R1 n32", 65'({c32, s32}), 65'(a32) + 65'(b32));
    chk("R1 n64", 65'({c64, s64}), 65'(a64) + 65'(b64));
    chk("R1 n12", 65'({c12, s12}), 65'(a12) + 65'(b12));
    chk("R1 n8 exhaustive", 65'({c8, s8}), 65'(a8) + 65'(b8));
    chk("R6 n32 no ripple", 65'({cz, sz}), 65'(az) + 65'(bz));
    chk("R6 n6 ripple only", 65'({c6, s6}), 65'(a6) + 65'(b6));
    chk("R6 n5 select only", 65'({c5, s5}), 65'(a5) + 65'(b5));
    lo7  = 8'(a32[6:0]) + 8'(b32[6:0]);
    chk("R2 low slice", 65'(s32[6:0]), 65'(lo7[6:0]));
    chk("R3 bit7", 65'(s32[7]), 65'(a32[7] ^ b32[7] ^ lo7[7]));
    lo23 = 24'(a32[22:0]) + 24'(b32[22:0]);
    chk("R4 bit23", 65'(s32[23]), 65'(a32[23] ^ b32[23] ^ lo23[23]));
    lo27 = 28'(a32[26:0]) + 28'(b32[26:0]);
    chk("R5 seg3", 65'(s32[26:23]), 65'(4'(5'(a32[26:23]) + 5'(b32[26:23]) + 5'(lo23[23]))));
    seg4 = 6'(a32[31:27]) + 6'(b32[31:27]) + 6'(lo27[27]);
    chk("R5 seg4", 65'({c32, s32[31:27]}), 65'(seg4));
    lo42 = 43'(a64[41:0]) + 43'(b64[41:0]);
    chk("R5 n64 seg3", 65'(s64[52:42]), 65'(11'(12'(a64[52:42]) + 12'(b64[52:42]) + 12'(lo42[42]))));
  end

  initial begin
    a32 = '0; b32 = '0; az = '0; bz = '0; a64 = '0; b64 = '0;
    a12 = '0; b12 = '0; a8 = '0; b8 = '0; a6 = '0; b6 = '0; a5 = '0; b5 = '0;
    repeat (2) @(posedge clk);
    run = 1'b1;

    drive(64'd0, 64'd0, 16'd0);
    @(negedge clk);
    chk("R7 zero n32", 65'({c32, s32}), 65'd0);
    chk("R7 zero n64", 65'({c64, s64}), 65'd0);

    drive({64{1'b1}}, 64'd1, 16'h01FF);
    @(negedge clk);
    chk("R7 ones+1 n32", 65'({c32, s32}), 65'h1_0000_0000);
    chk("R7 ones+1 n64", 65'({c64, s64}), {1'b1, 64'd0});
    chk("R7 ones+1 n8", 65'({c8, s8}), 65'h100);

    drive({64{1'b1}}, {64{1'b1}}, 16'hFFFF);
    @(negedge clk);
    chk("R7 ones+ones n32", 65'({c32, s32}), 65'h1_FFFF_FFFE);
    chk("R7 ones+ones n64", 65'({c64, s64}), {1'b1, {63{1'b1}}, 1'b0});

    drive(64'h0000_0000_007F_FFFF, 64'h0000_0000_0000_0001, 16'h0);
    drive(64'h0000_0000_07FF_FFFF, 64'h0000_0000_0000_0080, 16'h0);
    drive(64'h00FF_FFFF_FFFF_FF80, 64'h0000_0000_0000_0080, 16'h0);

    for (int i = 0; i < 65536; i++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, 16'(i));
    end
    for (int i = 0; i < 20000; i++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, 16'($urandom));
    end
    @(negedge clk);
    run = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule